// File: doc/BRIEF.md
# Logarithmic Channel Volume Combiner

This block turns a per-channel linear volume word and a master volume word into a 7-bit analog attenuation code for one DAC channel of an audio codec. It then issues the register writes that apply that code. The two 7-bit levels are multiplied together and scaled back by 127. The result is mapped through a decibel curve held in an internal constant table. The final code is written twice to the channel's attenuation register: first as a plain value, then with the latch and update flags set, so that the new value takes effect in one step.

A start strobe launches either one channel or a sweep. In a sweep, every second channel is refreshed, beginning at the selected one. This serves a master volume change, which has to be pushed to all left-side or all right-side DACs. Write requests leave through a valid/ready handshake toward a serial control-port writer that lies outside this block.

Top module: `log_vol_combiner`

## Requirements
- R1: When the mute flag (bit 15) of the channel word or of the master word is set, the written attenuation code is 0.
- R2: Without mute, the code is 127 minus T[i], where i = (channel level × master level) / 127 (integer division, kept to 8 bits). The levels are bits 6:0 of each word; bits 14:7 have no effect.
- R3: T[x] is 20·log10(255/x) rounded to the nearest integer for x ≥ 1, and T[0] is 127, so a zero level on either side gives code 0.
- R4: The first write of each pair goes to address BASE_ADDR + channel, with data bits 8:7 = 00 and bits 6:0 = code.
- R5: The next write is issued right after the first is accepted. It goes to the same address, with bits 8:7 = 11 and the same code in bits 6:0.
- R6: While wr_valid_o is high and wr_ready_i is low, wr_addr_o and wr_data_o hold their values.
- R7: With sweep_i set at start, the channels chan_sel, chan_sel+2, … below NUM_DAC are each updated with one write pair, in ascending order, all using the master word.
- R8: busy_o rises in the cycle after an accepted start and stays high until the last write is accepted. A start_i pulse while busy_o is high has no effect.
- R9: done_o pulses high for one cycle, with busy_o low, in the cycle after the last write is accepted.
- R10: After reset, busy_o, wr_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| sweep_i | input | 1 | 1: step by 2 across channels; 0: one channel |
| chan_sel_i | input | 3 | First (or only) channel index |
| chan_words_i | input | 128 | Eight 16-bit channel volume words, channel n in bits 16n+15:16n |
| master_word_i | input | 16 | Master volume word |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 7 | Codec register address |
| wr_data_o | output | 9 | Codec register data |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong table entry or a wrong divider step shows up as a wrong code in bits 6:0 of the first write, about twenty cycles after start. Sweeping every channel level against several master levels reaches most table entries that the product can index. A corrupted state or channel index shows up as a missing or extra write, a wrong address or a lost flag pair within the same update. It also shows up as busy_o failing to drop with the done pulse. A stalling ready pattern brings out any data that is not held under back-pressure.

// File: rtl/log_vol_pkg.sv
package log_vol_pkg;

  // 20*log10(2) in Q16
  localparam longint DB_PER_OCT_Q16 = 64'd394566;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_WR_PRE,
    ST_WR_UPD
  } lvc_state_e;

  // log2(v) in Q16, bitwise squaring method, v >= 1
  function automatic longint log2_q16(input longint v);
    longint m;
    longint r;
    int     n;
    n = 0;
    for (int i = 0; i < 40; i++)
      if ((v >> i) != 0) n = i;
    m = v << (30 - n);
    r = longint'(n) << 16;
    for (int b = 15; b >= 0; b--) begin
      m = (m * m) >> 30;
      if (m >= (longint'(1) << 31)) begin
        r = r + (longint'(1) << b);
        m = m >> 1;
      end
    end
    return r;
  endfunction

  // rounded 20*log10(full/x), saturating at sat
  function automatic int db_entry(input int x, input int full, input int sat);
    longint d;
    longint p;
    int     y;
    if (x == 0) return sat;
    d = log2_q16(longint'(full)) - log2_q16(longint'(x));
    p = d * DB_PER_OCT_Q16 + (longint'(1) << 31);
    y = int'(p >>> 32);
    return (y > sat) ? sat : y;
  endfunction

endpackage

// File: rtl/lvc_db_rom.sv
module lvc_db_rom #(
  parameter int IDX_W  = 8,
  parameter int CODE_W = 7
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CODE_W-1:0] code_o
);
  import log_vol_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int FULL  = DEPTH - 1;
  localparam int SAT   = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int ENT = db_entry(g, FULL, SAT);
    assign tab[g] = CODE_W'(ENT);
  end

  assign code_o = tab[idx_i];
endmodule

// File: rtl/lvc_seq_div.sv
module lvc_seq_div #(
  parameter int DIVIDEND_W = 14,
  parameter int DIVISOR_W  = 7,
  parameter int DIVISOR    = 127
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [DIVIDEND_W-1:0] dividend_i,
  output logic                  valid_o,
  output logic [DIVIDEND_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DIVIDEND_W + 1);
  localparam logic [DIVISOR_W:0] DIV_V = (DIVISOR_W + 1)'(DIVISOR);

  logic [DIVISOR_W-1:0]  rem_q;
  logic [DIVIDEND_W-1:0] quot_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  run_q, valid_q;
  logic [DIVISOR_W:0]    rem_sh, rem_nx;
  logic                  ge;

  always_comb begin
    rem_sh = {rem_q, quot_q[DIVIDEND_W-1]};
    ge     = rem_sh >= DIV_V;
    rem_nx = ge ? rem_sh - DIV_V : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quot_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      rem_q   <= '0;
      quot_q  <= dividend_i;
      cnt_q   <= CNT_W'(DIVIDEND_W);
      run_q   <= 1'b1;
      valid_q <= 1'b0;
    end else if (run_q) begin
      quot_q <= {quot_q[DIVIDEND_W-2:0], ge};
      rem_q  <= rem_nx[DIVISOR_W-1:0];
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = quot_q;
endmodule

// File: rtl/log_vol_combiner.sv
module log_vol_combiner #(
  parameter int NUM_DAC   = 8,
  parameter int LVL_W     = 7,
  parameter int WORD_W    = 16,
  parameter int MUTE_BIT  = 15,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 9,
  parameter int BASE_ADDR = 0,
  parameter int IDX_W     = 8,
  localparam int SEL_W    = $clog2(NUM_DAC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      sweep_i,
  input  logic [SEL_W-1:0]          chan_sel_i,
  input  logic [NUM_DAC*WORD_W-1:0] chan_words_i,
  input  logic [WORD_W-1:0]         master_word_i,
  output logic                      wr_valid_o,
  input  logic                      wr_ready_i,
  output logic [ADDR_W-1:0]         wr_addr_o,
  output logic [DATA_W-1:0]         wr_data_o,
  output logic                      busy_o,
  output logic                      done_o
);
  import log_vol_pkg::*;

  localparam int PROD_W = 2 * LVL_W;
  localparam int FULL_LVL = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] FULL_CODE = LVL_W'(FULL_LVL);
  localparam logic [DATA_W-1:0] UPD_FLAGS = DATA_W'(3) << (DATA_W - 2);

  lvc_state_e          state_q;
  logic [SEL_W-1:0]    sel_q;
  logic                sweep_q, mute_q, done_q;
  logic [LVL_W-1:0]    code_q;
  logic [WORD_W-1:0]   cur_word;
  logic [PROD_W-1:0]   product;
  logic                div_valid;
  logic [PROD_W-1:0]   quot;
  logic [LVL_W-1:0]    rom_code;
  logic                wr_fire;
  logic                last_chan;
  logic                unused_bits;

  assign cur_word  = chan_words_i[sel_q*WORD_W +: WORD_W];
  assign product   = PROD_W'(cur_word[LVL_W-1:0]) * PROD_W'(master_word_i[LVL_W-1:0]);
  assign wr_fire   = wr_valid_o && wr_ready_i;
  assign last_chan = !sweep_q || (int'(sel_q) + 2 >= NUM_DAC);
  assign unused_bits = ^quot[PROD_W-1:IDX_W] ^ ^master_word_i[MUTE_BIT-1:LVL_W];

  lvc_seq_div #(
    .DIVIDEND_W(PROD_W),
    .DIVISOR_W (LVL_W),
    .DIVISOR   (FULL_LVL)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (state_q == ST_LOAD),
    .dividend_i(product),
    .valid_o   (div_valid),
    .quot_o    (quot)
  );

  lvc_db_rom #(
    .IDX_W (IDX_W),
    .CODE_W(LVL_W)
  ) u_rom (
    .idx_i (quot[IDX_W-1:0]),
    .code_o(rom_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      sweep_q <= 1'b0;
      mute_q  <= 1'b0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sel_q   <= chan_sel_i;
          sweep_q <= sweep_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          mute_q  <= cur_word[MUTE_BIT] | master_word_i[MUTE_BIT];
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_valid) begin
          code_q  <= mute_q ? '0 : FULL_CODE - rom_code;
          state_q <= ST_WR_PRE;
        end
        ST_WR_PRE: if (wr_fire) state_q <= ST_WR_UPD;
        ST_WR_UPD: if (wr_fire) begin
          if (last_chan) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            sel_q   <= sel_q + SEL_W'(2);
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q == ST_WR_PRE) || (state_q == ST_WR_UPD);
  assign wr_addr_o  = ADDR_W'(BASE_ADDR) + ADDR_W'(sel_q);
  assign wr_data_o  = (state_q == ST_WR_UPD) ? (DATA_W'(code_q) | UPD_FLAGS) : DATA_W'(code_q);
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = done_q;
endmodule

// File: rtl/lvc_checker.sv
module lvc_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              busy_o,
  input logic              done_o
);
  logic [1:0] flags;
  assign flags = wr_data_o[DATA_W-1:DATA_W-2];

  p_flag_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (flags == 2'b00 || flags == 2'b11));

  p_upd_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && flags == 2'b00) |=>
      (wr_valid_o && flags == 2'b11 && $stable(wr_addr_o) &&
       wr_data_o[DATA_W-3:0] == $past(wr_data_o[DATA_W-3:0])));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_valid_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> busy_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !wr_valid_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind log_vol_combiner lvc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/log_vol_combiner_bench.sv
`timescale 1ns/1ps
module log_vol_combiner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         sweep = 1'b0;
  logic [2:0]   chan_sel = '0;
  logic [127:0] words = '0;
  logic [15:0]  master = '0;
  logic         ready = 1'b1;
  logic         wr_valid;
  logic [6:0]   wr_addr;
  logic [8:0]   wr_data;
  logic         busy, done;

  int  tests = 0;
  int  fails = 0;
  int  cyc = 0;
  bit  stall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  log_vol_combiner u_log_vol_combiner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sweep_i(sweep),
    .chan_sel_i(chan_sel), .chan_words_i(words), .master_word_i(master),
    .wr_valid_o(wr_valid), .wr_ready_i(ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int tab(input int x);
    if (x == 0) return 127;
    return int'($floor(20.0 * $log10(255.0 / x) + 0.5));
  endfunction

  function automatic int exp_code(input logic [15:0] cw, input logic [15:0] mw);
    if (cw[15] || mw[15]) return 0;
    return 127 - tab(((int'(cw[6:0]) * int'(mw[6:0])) / 127) & 255);
  endfunction

  // returns at the negedge before the accepting posedge
  task automatic get_wr(output logic [6:0] a, output logic [8:0] d);
    int  n = 0;
    bit  seen = 1'b0;
    logic [6:0] ha = '0;
    logic [8:0] hd = '0;
    forever begin
      @(negedge clk);
      ready = stall ? (n % 3 == 2) : 1'b1;
      n++;
      if (wr_valid && !ready && !seen) begin
        seen = 1'b1; ha = wr_addr; hd = wr_data;
      end
      if (wr_valid && ready) begin
        a = wr_addr; d = wr_data;
        if (seen) chk(ha == a && hd == d, "R6 hold under stall", int'({a, d}), int'({ha, hd}));
        break;
      end
    end
  endtask

  task automatic kick(input bit sw, input int sel);
    @(negedge clk);
    sweep = sw; chan_sel = 3'(sel); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
  endtask

  task automatic expect_pair(input int ch, input int code, input string req);
    logic [6:0] a;
    logic [8:0] d;
    get_wr(a, d);
    chk(a == 7'(ch), "R4 pre address", int'(a), ch);
    chk(d == 9'(code), req, int'(d), code);
    get_wr(a, d);
    chk(a == 7'(ch) && d == (9'(code) | 9'h180), "R5 update write", int'({a, d}), int'({7'(ch), 9'(code) | 9'h180}));
  endtask

  task automatic expect_done();
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R9 done pulse", int'({done, busy}), 2);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic run_single(input int ch, input logic [15:0] cw, input logic [15:0] mw, input string req);
    words[ch*16 +: 16] = cw;
    master = mw;
    kick(1'b0, ch);
    expect_pair(ch, exp_code(cw, mw), req);
    expect_done();
  endtask

  task automatic run_sweep(input int side);
    kick(1'b1, side);
    for (int ch = side; ch < 8; ch += 2)
      expect_pair(ch, exp_code(words[ch*16 +: 16], master), "R7 sweep code");
    expect_done();
  endtask

  initial begin
    int mlist [4] = '{127, 90, 64, 3};
    repeat (3) @(negedge clk);
    chk(busy == 0 && wr_valid == 0 && done == 0, "R10 reset state", int'({busy, wr_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && wr_valid == 0 && done == 0, "R10 idle after reset", int'({busy, wr_valid, done}), 0);

    // R2 / R3: channel level sweep against several master levels
    for (int mi = 0; mi < 4; mi++)
      for (int c = 0; c < 128; c++) begin
        logic [15:0] cw;
        cw = {1'b0, (c % 5 == 0) ? 8'hA5 : 8'h00, 7'(c)};
        run_single(c % 8, cw, {1'b0, 8'h5A, 7'(mlist[mi])}, (c == 0) ? "R3 zero level" : "R2 combined code");
      end
    // R3: master level sweep, channel full
    for (int m = 0; m < 128; m++)
      run_single(m % 8, 16'd127, 16'(m), (m == 0) ? "R3 zero master" : "R2 master sweep");

    // R1: mute flags
    run_single(1, 16'h807F, 16'h007F, "R1 channel mute");
    run_single(2, 16'h007F, 16'h807F, "R1 master mute");
    run_single(3, 16'h8040, 16'h8040, "R1 both muted");
    run_single(4, 16'h0040, 16'h0040, "R1 unmuted reference");

    // R6: back-pressure
    stall = 1'b1;
    for (int c = 10; c < 128; c += 13) run_single(c % 8, 16'(c), 16'd100, "R6 code under stall");
    stall = 1'b0;

    // R7: sweeps
    for (int ch = 0; ch < 8; ch++) words[ch*16 +: 16] = 16'(20 + ch * 13);
    words[5*16 +: 16] = 16'h8070;
    master = 16'd110;
    run_sweep(0);
    run_sweep(1);
    stall = 1'b1;
    run_sweep(1);
    stall = 1'b0;
    master = 16'h807F;
    run_sweep(0);
    master = 16'd127;
    run_sweep(6);

    // R8: start while busy is ignored
    words[2*16 +: 16] = 16'd77;
    master = 16'd99;
    kick(1'b0, 2);
    chan_sel = 3'd5; sweep = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_pair(2, exp_code(16'd77, 16'd99), "R8 original request");
    expect_done();
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (wr_valid || busy) extra++;
      end
      chk(extra == 0, "R8 ignored start", extra, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule